// File: doc/BRIEF.md
# Multiplexed Bus Target Claim and Data Phase Controller

This block is the target side of a parallel bus on which address and data share one set of wires. When an initiator opens a transaction, the block captures the address and command in the single cycle they are valid. A two-cycle wide-address form is also accepted, with the low half first and the high half second. The block then decides whether the address falls inside its window. It claims the transaction by asserting device-select after a fast, medium or slow delay. As a fallback it can claim unmatched memory commands one cycle after the slow window, provided no other target has answered by then.

Once a transaction is claimed, the block runs data phases with a ready handshake toward the initiator. Beats are offered to a local port as one-cycle transfer pulses that carry the beat address and the write data. For reads, the local side supplies the data word for the current beat address. The local side can ask to end the burst after the current beat. When the transaction ends, the block drives its control lines inactive for one cycle before it releases them.

Top module: `busTargetTop`

## Requirements
- R1: The address is taken from `adIn` in the cycle `frameN` first goes low. Only memory read (`cbeN`=0110) and memory write (`cbeN`=0111) commands whose address matches `BASE_ADDR` under `ADDR_MASK` are claimed by decode. An unmatched or other command leaves `ctlOe` low unless R3 applies.
- R2: For a decode hit, `devselN` is driven low with `ctlOe` high in cycle a+1, a+2 or a+3, where a is the address cycle. The cycle is chosen by `claimSpeed` 0, 1 or 2; the value 3 acts as 2. `trdyN` is never low while `devselN` is high.
- R3: With `subtractiveEn` high, a memory command that missed the window is claimed in cycle a+4. This happens only if `busDevselN` stayed high through cycles a+1 to a+3.
- R4: On a read, the target neither drives `adOut` (`adOe` low) nor asserts `trdyN` in cycle a+1.
- R5: In every cycle of a read where `trdyN` is low, `adOe` is high and `adOut` holds the local read data for the current beat address.
- R6: Once `trdyN` is low, it stays low, and `stopN` and `devselN` stay unchanged, until a cycle with `irdyN` low completes the phase.
- R7: A first address cycle with `cbeN`=1101 marks a two-cycle address. The next cycle carries the high half and the real command, and the claim delay counts from that second cycle. A high half of zero is ignored entirely, with no subtractive claim.
- R8: A beat transfers only in a cycle where both `irdyN` and `trdyN` are low. In that cycle `lclValid` pulses with `lclAddr` (the start address aligned to a word, plus 4 per earlier beat), `lclWrite` and, for writes, `lclWdata` = `adIn`.
- R9: `lclDisconnect` sampled when `trdyN` is armed makes `stopN` low together with `trdyN`. If that beat transfers while `frameN` is low, the next cycle has `trdyN` high while `stopN` and `devselN` stay low until `frameN` is high. If `frameN` is already high at that transfer, release follows at once with no extra cycle.
- R10: After the final phase, there is one cycle with `ctlOe` high and `devselN`, `trdyN` and `stopN` all high. In the next cycle `ctlOe` is low.
- R11: In reset, `ctlOe`, `adOe` and `lclValid` are low, and `devselN`, `trdyN` and `stopN` are high.
- R12: After every transfer, `trdyN` is high for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameN | input | 1 | Transaction framing from the initiator, active low |
| irdyN | input | 1 | Initiator ready, active low |
| busDevselN | input | 1 | Device-select as driven by other targets, active low |
| cbeN | input | 4 | Command in address cycles, byte enables otherwise |
| adIn | input | DATA_W | Address/data bus as seen by the target |
| claimSpeed | input | 2 | Claim delay select: 0 fast, 1 medium, 2 or 3 slow |
| subtractiveEn | input | 1 | Enables the fallback claim |
| adOut | output | DATA_W | Read data driven onto the bus |
| adOe | output | 1 | Output enable for `adOut` |
| devselN | output | 1 | Device-select, active low |
| trdyN | output | 1 | Target ready, active low |
| stopN | output | 1 | Disconnect request, active low |
| ctlOe | output | 1 | Output enable for `devselN`, `trdyN`, `stopN` |
| lclValid | output | 1 | One-cycle pulse per transferred beat |
| lclWrite | output | 1 | High for write transactions |
| lclAddr | output | 2*DATA_W | Address of the current beat |
| lclWdata | output | DATA_W | Write data of the transferring beat |
| lclRdata | input | DATA_W | Read data for `lclAddr` |
| lclReady | input | 1 | Local side can complete the next beat |
| lclDisconnect | input | 1 | Ask to end the burst after the armed beat |

## Verification
The assertions take for granted that the initiator follows the bus rules. It holds `frameN` high for at least one cycle between transactions, and it never raises `frameN` while `irdyN` is high in a data phase. After the target has asserted `stopN`, it raises `frameN` within a cycle. The bench initiator model obeys these rules by construction. It drives `irdyN` low whenever `frameN` is high in a data phase. It chooses only at random whether to react to a stop at once or one cycle later. Random choices cover readiness, disconnect requests, window hits and command codes. The claim delay, the other target's claim and the high address half are also random.

// File: rtl/busTgtPkg.sv
package busTgtPkg;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_DUAL   = 4'b1101;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HIADDR,
    ST_DECODE,
    ST_DATA,
    ST_STOPWAIT,
    ST_TURNOFF,
    ST_IGNORE
  } tgtState_e;

  typedef struct packed {
    logic capLo;      // take low address half / single address
    logic capHi;      // take high address half
    logic capCmd;     // take command and start beat address
    logic incBeat;    // advance beat address
    logic loadRdata;  // register local read data onto the bus
  } dpStrobe_t;

endpackage

// File: rtl/busTgtDatapath.sv
module busTgtDatapath
  import busTgtPkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [2*DATA_W-1:0] BASE_ADDR = 64'h0000_0000_8000_0000,
  parameter logic [2*DATA_W-1:0] ADDR_MASK = 64'h0000_0000_FFFF_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [DATA_W-1:0]     adIn,
  input  logic [3:0]            cbeN,
  input  logic [DATA_W-1:0]     lclRdata,
  output logic                  addrMatch,
  output logic                  cmdOk,
  output logic                  cmdRdNow,
  output logic                  hiZero,
  output logic                  cmdIsRead,
  output logic [2*DATA_W-1:0]   beatAddr,
  output logic [DATA_W-1:0]     adOut
);

  localparam int FULL_W = 2 * DATA_W;
  localparam int BYTES  = DATA_W / 8;
  localparam logic [FULL_W-1:0] STEP       = FULL_W'(BYTES);
  localparam logic [FULL_W-1:0] ALIGN_MASK = ~(FULL_W'(BYTES - 1));

  logic [DATA_W-1:0] addrLo;
  logic [FULL_W-1:0] candidate;

  // Address under decode: the live bus word, joined with the stored
  // low half when the high half of a wide address is on the bus.
  always_comb begin
    candidate = strobe.capHi ? {adIn, addrLo} : {{DATA_W{1'b0}}, adIn};
    addrMatch = (candidate & ADDR_MASK) == (BASE_ADDR & ADDR_MASK);
    cmdRdNow  = (cbeN == CMD_MEM_RD);
    cmdOk     = cmdRdNow || (cbeN == CMD_MEM_WR);
    hiZero    = (adIn == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLo    <= '0;
      cmdIsRead <= 1'b0;
      beatAddr  <= '0;
      adOut     <= '0;
    end else begin
      if (strobe.capLo)     addrLo <= adIn;
      if (strobe.capCmd) begin
        cmdIsRead <= cmdRdNow;
        beatAddr  <= candidate & ALIGN_MASK;
      end else if (strobe.incBeat) begin
        beatAddr  <= beatAddr + STEP;
      end
      if (strobe.loadRdata) adOut <= lclRdata;
    end
  end

endmodule

// File: rtl/busTgtControl.sv
module busTgtControl
  import busTgtPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       irdyN,
  input  logic       busDevselN,
  input  logic [3:0] cbeN,
  input  logic [1:0] claimSpeed,
  input  logic       subtractiveEn,
  input  logic       lclReady,
  input  logic       lclDisconnect,
  input  logic       addrMatch,
  input  logic       cmdOk,
  input  logic       cmdRdNow,
  input  logic       hiZero,
  input  logic       cmdIsRead,
  output dpStrobe_t  strobe,
  output logic       devselN,
  output logic       trdyN,
  output logic       stopN,
  output logic       ctlOe,
  output logic       adOe,
  output logic       lclValid
);

  localparam logic [1:0] SUB_CNT = 2'd3;

  tgtState_e  st;
  logic [1:0] cnt;
  logic       hitR, cmdOkR, otherSeen, prevFrameN;
  logic       startNow, dualNow, hitNow, otherNow, xfer, armTrdy;
  logic       claimAddr, claimDecode, readSel;
  logic [2:0] lat;

  always_comb begin
    unique case (claimSpeed)
      2'd0:    lat = 3'd1;
      2'd1:    lat = 3'd2;
      default: lat = 3'd3;
    endcase
    startNow  = (st == ST_IDLE) && !frameN && prevFrameN;
    dualNow   = startNow && (cbeN == CMD_DUAL);
    hitNow    = addrMatch && cmdOk;
    otherNow  = otherSeen || !busDevselN;
    xfer      = (st == ST_DATA) && !irdyN && !trdyN;
    armTrdy   = (st == ST_DATA) && trdyN && lclReady;

    strobe           = '0;
    strobe.capLo     = startNow;
    strobe.capHi     = (st == ST_HIADDR);
    strobe.capCmd    = (startNow && !dualNow) || (st == ST_HIADDR);
    strobe.incBeat   = xfer;

    claimAddr   = strobe.capCmd && hitNow && (lat == 3'd1) &&
                  !((st == ST_HIADDR) && hiZero);
    claimDecode = (st == ST_DECODE) &&
                  ((hitR && (lat == ({1'b0, cnt} + 3'd1))) ||
                   ((cnt == SUB_CNT) && subtractiveEn && !hitR && cmdOkR && !otherNow));
    readSel     = claimAddr ? cmdRdNow : cmdIsRead;
    strobe.loadRdata = armTrdy || (claimDecode && lclReady);
    lclValid    = xfer;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      hitR       <= 1'b0;
      cmdOkR     <= 1'b0;
      otherSeen  <= 1'b0;
      prevFrameN <= 1'b1;
      devselN    <= 1'b1;
      trdyN      <= 1'b1;
      stopN      <= 1'b1;
      ctlOe      <= 1'b0;
      adOe       <= 1'b0;
    end else begin
      prevFrameN <= frameN;
      unique case (st)
        ST_IDLE: begin
          if (startNow) begin
            otherSeen <= 1'b0;
            cnt       <= 2'd1;
            hitR      <= hitNow;
            cmdOkR    <= cmdOk;
            st        <= dualNow ? ST_HIADDR : ST_DECODE;
          end
        end
        ST_HIADDR: begin
          cnt    <= 2'd1;
          hitR   <= hitNow;
          cmdOkR <= cmdOk;
          st     <= hiZero ? ST_IGNORE : ST_DECODE;
        end
        ST_DECODE: begin
          otherSeen <= otherNow;
          cnt       <= cnt + 2'd1;
          if (cnt == SUB_CNT) st <= ST_IGNORE;
        end
        ST_DATA: begin
          if (xfer) begin
            trdyN <= 1'b1;
            if (frameN) begin
              st      <= ST_TURNOFF;
              devselN <= 1'b1;
              stopN   <= 1'b1;
              adOe    <= 1'b0;
            end else if (!stopN) begin
              st   <= ST_STOPWAIT;
              adOe <= 1'b0;
            end
          end else if (armTrdy) begin
            trdyN <= 1'b0;
            stopN <= !lclDisconnect;
            adOe  <= cmdIsRead;
          end
        end
        ST_STOPWAIT: begin
          if (frameN) begin
            st      <= ST_TURNOFF;
            devselN <= 1'b1;
            stopN   <= 1'b1;
          end
        end
        ST_TURNOFF: begin
          ctlOe <= 1'b0;
          st    <= ST_IDLE;
        end
        ST_IGNORE: begin
          if (frameN && irdyN) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase

      // A claim overrides the per-state update above.
      if (claimAddr || claimDecode) begin
        st      <= ST_DATA;
        ctlOe   <= 1'b1;
        devselN <= 1'b0;
        if (lclReady && !(claimAddr && readSel)) begin
          trdyN <= 1'b0;
          stopN <= !lclDisconnect;
          adOe  <= readSel;
        end
      end
    end
  end

endmodule

// File: rtl/busTargetTop.sv
module busTargetTop
  import busTgtPkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [2*DATA_W-1:0] BASE_ADDR = 64'h0000_0000_8000_0000,
  parameter logic [2*DATA_W-1:0] ADDR_MASK = 64'h0000_0000_FFFF_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameN,
  input  logic                irdyN,
  input  logic                busDevselN,
  input  logic [3:0]          cbeN,
  input  logic [DATA_W-1:0]   adIn,
  input  logic [1:0]          claimSpeed,
  input  logic                subtractiveEn,
  output logic [DATA_W-1:0]   adOut,
  output logic                adOe,
  output logic                devselN,
  output logic                trdyN,
  output logic                stopN,
  output logic                ctlOe,
  output logic                lclValid,
  output logic                lclWrite,
  output logic [2*DATA_W-1:0] lclAddr,
  output logic [DATA_W-1:0]   lclWdata,
  input  logic [DATA_W-1:0]   lclRdata,
  input  logic                lclReady,
  input  logic                lclDisconnect
);

  dpStrobe_t strobe;
  logic addrMatch, cmdOk, cmdRdNow, hiZero, cmdIsRead;

  busTgtDatapath #(
    .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR), .ADDR_MASK(ADDR_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .adIn(adIn), .cbeN(cbeN),
    .lclRdata(lclRdata), .addrMatch(addrMatch), .cmdOk(cmdOk),
    .cmdRdNow(cmdRdNow), .hiZero(hiZero), .cmdIsRead(cmdIsRead),
    .beatAddr(lclAddr), .adOut(adOut)
  );

  busTgtControl u_ctl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN),
    .busDevselN(busDevselN), .cbeN(cbeN), .claimSpeed(claimSpeed),
    .subtractiveEn(subtractiveEn), .lclReady(lclReady),
    .lclDisconnect(lclDisconnect), .addrMatch(addrMatch), .cmdOk(cmdOk),
    .cmdRdNow(cmdRdNow), .hiZero(hiZero), .cmdIsRead(cmdIsRead),
    .strobe(strobe), .devselN(devselN), .trdyN(trdyN), .stopN(stopN),
    .ctlOe(ctlOe), .adOe(adOe), .lclValid(lclValid)
  );

  assign lclWrite = !cmdIsRead;
  assign lclWdata = adIn;

endmodule

// File: rtl/busTargetChecker.sv
module busTargetChecker (
  input logic clk,
  input logic rstN,
  input logic irdyN,
  input logic devselN,
  input logic trdyN,
  input logic stopN,
  input logic ctlOe,
  input logic adOe,
  input logic lclValid,
  input logic lclWrite,
  input logic capLo
);

  assert_trdy_inside_claim_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctlOe && !trdyN) |-> !devselN);

  assert_read_turnaround_R4: assert property (@(posedge clk) disable iff (!rstN)
    capLo |=> !adOe);

  assert_read_data_driven_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctlOe && !trdyN && !lclWrite) |-> adOe);

  assert_ready_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctlOe && !trdyN && irdyN) |=> (!trdyN && $stable(stopN) && $stable(devselN)));

  assert_beat_handshake_R8: assert property (@(posedge clk) disable iff (!rstN)
    lclValid |-> (!irdyN && !trdyN && ctlOe));

  assert_release_high_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctlOe) |-> $past(devselN && trdyN && stopN));

  assert_gap_after_beat_R12: assert property (@(posedge clk) disable iff (!rstN)
    lclValid |=> trdyN);

endmodule

bind busTargetTop busTargetChecker u_chk (
  .clk(clk), .rstN(rstN), .irdyN(irdyN), .devselN(devselN), .trdyN(trdyN),
  .stopN(stopN), .ctlOe(ctlOe), .adOe(adOe), .lclValid(lclValid),
  .lclWrite(lclWrite), .capLo(strobe.capLo)
);

// File: tb/tb_busTargetTop.sv
module tb_busTargetTop;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam logic [63:0] BASE = 64'h0000_0000_8000_0000;
  localparam logic [63:0] MASK = 64'h0000_0000_FFFF_0000;
  localparam logic [3:0] RD = 4'b0110, WR = 4'b0111, DUAL = 4'b1101;

  logic clk = 0, rstN = 0;
  logic frameN = 1, irdyN = 1, busDevselN = 1, subtractiveEn = 0;
  logic [3:0] cbeN = 4'hF;
  logic [DATA_W-1:0] adIn = '0, adOut, lclWdata, lclRdata;
  logic [1:0] claimSpeed = 0;
  logic adOe, devselN, trdyN, stopN, ctlOe, lclValid, lclWrite;
  logic [63:0] lclAddr;
  logic lclReady = 0, lclDisconnect = 0;
  int checks = 0, errors = 0;

  busTargetTop #(.DATA_W(DATA_W), .BASE_ADDR(BASE), .ADDR_MASK(MASK)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] dataFn(input logic [63:0] a);
    return a[31:0] ^ {a[47:32], a[63:48]} ^ 32'h5A5A_1234;
  endfunction

  function automatic logic [31:0] wdataFn(input logic [63:0] a);
    return ~dataFn(a) + 32'h11;
  endfunction

  // Expected claim cycle after the (last) address cycle; 0 means no claim.
  function automatic int expLat(input bit dac, input logic [31:0] hi, input logic [31:0] lo,
                                input logic [3:0] cmd, input int speed, input bit sub, input bit other);
    bit okCmd = (cmd == RD) || (cmd == WR);
    logic [63:0] a = {dac ? hi : 32'h0, lo};
    if (dac && hi == 0) return 0;
    if (okCmd && ((a & MASK) == (BASE & MASK))) return (speed == 0) ? 1 : (speed == 1) ? 2 : 3;
    if (okCmd && sub && !other) return 4;
    return 0;
  endfunction

  assign lclRdata = dataFn(lclAddr);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic txn(input bit dac, input logic [31:0] hi, input logic [31:0] lo,
                     input logic [3:0] cmd, input int speed, input bit sub, input bit other,
                     input int beats, input int readyPct, input int discPct, input bit lazy);
    int exp = expLat(dac, hi, lo, cmd, speed, sub, other);
    bit isWr = (cmd == WR);
    logic [63:0] addr = {dac ? hi : 32'h0, lo} & ~64'h3;
    int remaining = beats;
    int phase = 0;
    int j = 0;
    bit afterXfer = 0, prevHeld = 0, prevStop = 1, xfer;
    string latTag = (exp == 4) ? "R3" : (dac ? "R7" : "R2");
    @(negedge clk);
    claimSpeed = 2'(speed); subtractiveEn = sub;
    frameN = 0; irdyN = 1; adIn = lo; cbeN = dac ? DUAL : cmd;
    if (dac) begin
      @(negedge clk);
      adIn = hi; cbeN = cmd;
    end
    if (exp == 0) begin
      for (int k = 1; k <= 6; k++) begin
        @(negedge clk);
        chk(!ctlOe, (dac && hi == 0) ? "R7" : (other ? "R3" : "R1"), "no claim ctlOe", ctlOe, 0);
        irdyN = 0; adIn = 0; cbeN = 0;
        busDevselN = (other && k >= 2) ? 1'b0 : 1'b1;
      end
      @(negedge clk);
      frameN = 1; irdyN = 1; busDevselN = 1;
      @(negedge clk);
      return;
    end
    while (phase < 4 && j < 300) begin
      @(negedge clk);
      j++;
      if (phase == 0) begin
        if (j < exp) chk(!ctlOe || devselN, latTag, "early devsel", devselN, 1);
        if (j == exp) chk(ctlOe && !devselN, latTag, "claim cycle devsel", {ctlOe, devselN}, 2'b10);
        if (j == 1 && !isWr) chk(trdyN && !adOe, "R4", "turnaround trdy/adOe", {trdyN, adOe}, 2'b10);
        if (ctlOe && !trdyN && !isWr)
          chk(adOe && adOut == dataFn(addr), "R5", "read data", adOut, dataFn(addr));
        if (prevHeld) chk(!trdyN && stopN == prevStop, "R6", "ready held", {trdyN, stopN}, {1'b0, prevStop});
        if (afterXfer) chk(trdyN, "R12", "gap after beat", trdyN, 1);
        // initiator drive for this cycle
        if (remaining == 1 || (ctlOe && !stopN && !lazy)) frameN = 1;
        irdyN = frameN ? 1'b0 : (($urandom % 100) < 80 ? 1'b0 : 1'b1);
        adIn = isWr ? wdataFn(addr) : 32'h0;
        cbeN = 4'h0;
        lclReady = ($urandom % 100) < readyPct;
        lclDisconnect = ($urandom % 100) < discPct;
        #1;
        xfer = !irdyN && !trdyN && ctlOe;
        chk(lclValid == xfer, "R8", "transfer pulse", lclValid, xfer);
        if (xfer) begin
          chk(lclAddr == addr, "R8", "beat address", lclAddr, addr);
          chk(lclWrite == isWr, "R8", "write flag", lclWrite, isWr);
          if (isWr) chk(lclWdata == wdataFn(addr), "R8", "write data", lclWdata, wdataFn(addr));
          addr += 4;
          remaining--;
          if (frameN) phase = 2;
          else if (!stopN) phase = 1;
        end
        afterXfer = xfer;
        prevHeld = ctlOe && !trdyN && !xfer;
        prevStop = stopN;
      end else if (phase == 1) begin
        chk(ctlOe && trdyN && !stopN && !devselN, "R9", "stop wait lines",
            {ctlOe, trdyN, stopN, devselN}, 4'b1100);
        frameN = 1; irdyN = 1;
        phase = 2;
      end else if (phase == 2) begin
        chk(ctlOe && devselN && trdyN && stopN, (lazy || remaining > 0) ? "R9" : "R10",
            "turnoff all high", {ctlOe, devselN, trdyN, stopN}, 4'b1111);
        frameN = 1; irdyN = 1; lclReady = 0; lclDisconnect = 0;
        phase = 3;
      end else begin
        chk(!ctlOe, "R10", "released", ctlOe, 0);
        phase = 4;
      end
    end
    if (phase < 4) chk(0, "R8", "transaction hung", phase, 4);
    frameN = 1; irdyN = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R8", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!ctlOe && !adOe && !lclValid && devselN && trdyN && stopN, "R11", "reset outputs",
        {ctlOe, adOe, lclValid, devselN, trdyN, stopN}, 6'b000111);
    rstN = 1;
    repeat (2) @(negedge clk);

    // directed corner cases
    txn(0, 0, 32'h8000_0010, RD, 0, 0, 0, 3, 100, 0, 0);   // fast read, R4
    txn(0, 0, 32'h8000_0020, WR, 0, 0, 0, 3, 100, 0, 0);   // fast write
    txn(0, 0, 32'h8000_0104, RD, 1, 0, 0, 2, 100, 0, 0);   // medium read
    txn(0, 0, 32'h8000_0200, WR, 2, 0, 0, 4, 60, 0, 0);    // slow write
    txn(0, 0, 32'h8000_0300, RD, 3, 0, 0, 1, 100, 0, 0);   // speed 3 acts slow, R2
    txn(0, 0, 32'h1234_0000, RD, 0, 0, 0, 2, 100, 0, 0);   // miss, R1
    txn(0, 0, 32'h8000_0040, 4'b0010, 0, 0, 0, 1, 100, 0, 0); // other command, R1
    txn(0, 0, 32'h1234_0010, WR, 0, 1, 0, 3, 100, 0, 0);   // subtractive, R3
    txn(0, 0, 32'h1234_0020, RD, 0, 1, 1, 1, 100, 0, 0);   // other target claimed, R3
    txn(1, 32'h0000_0003, 32'h8000_0050, RD, 1, 0, 0, 2, 100, 0, 0); // wide address, R7
    txn(1, 32'h0000_0000, 32'h8000_0060, WR, 0, 1, 0, 2, 100, 0, 0); // zero high half, R7
    txn(0, 0, 32'h8000_0400, RD, 0, 0, 0, 5, 100, 100, 1); // disconnect, stop wait, R9
    txn(0, 0, 32'h8000_0500, WR, 1, 0, 0, 5, 100, 100, 0); // disconnect at final phase, R9

    // constrained random
    for (int n = 0; n < 60; n++) begin
      bit dac = ($urandom % 4) == 0;
      logic [31:0] hi = dac ? ((($urandom % 3) == 0) ? 32'h0 : 32'($urandom % 8 + 1)) : 32'h0;
      logic [31:0] lo = (($urandom % 4) == 0) ? $urandom : (32'h8000_0000 | ($urandom & 32'h0000_FFFC));
      int pick = $urandom % 10;
      logic [3:0] cmd = (pick < 5) ? RD : (pick < 9) ? WR : 4'b0011;
      txn(dac, hi, lo, cmd, $urandom % 4, $urandom % 2, ($urandom % 4) == 0,
          1 + $urandom % 6, 40 + $urandom % 61, $urandom % 30, $urandom % 2);
    end
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule